// File: doc/BRIEF.md
# Almost-Flag Offset Register Loader

This block holds the two threshold offsets a FIFO flag unit compares its fill level against: one for the almost-empty flag and one for the almost-full flag. Both offsets are independent, so each flag can switch at any fill level the buffer supports. The flag comparison itself lies outside the block. The block only provides the offset values and a way to change them or read them back.

At master reset the level of the load-select input picks two things. It sets the default value of both offsets, and it chooses how they may be reprogrammed later. With load-select low, the defaults are 127 and loading is done by words. With load-select high, the defaults are 1023 and loading is done by a serial bit stream. A word-wide readback path on the read clock returns the offsets in either mode. A partial reset restarts every load and readback sequence but keeps the offsets and the chosen mode.

With the default parameters the buffer is 16384 entries deep. Each offset is therefore 14 bits wide, and each offset takes two 9-bit transfers on the word bus.

Top module: `ofs_loader_top`

## Requirements
- R1: When `mrst` is high on a write-clock edge with `ld` low, both offsets become 127 and word loading is selected. The word-write step, the readback step and the serial bit position all return to their first position.
- R2: When `mrst` is high on a write-clock edge with `ld` high, both offsets become 1023 and serial loading is selected. The sequence positions are cleared as in R1.
- R3: In serial mode, a write-clock edge with `sen` and `ld` both high stores `sdi` into the next bit of one chain, and the offset output shows it after that edge.
  - The chain holds almost-empty bits 0 to W-1 first, then almost-full bits 0 to W-1, least significant bit first (W is the offset width).
  - After the last almost-full bit, the position wraps to almost-empty bit 0.
- R4: In word mode, a write-clock edge with `wen` and `ld` both high stores `wdata` into the next part in a fixed order, and the offset output shows it after that edge.
  - The order is: almost-empty low part (bits 8:0), almost-empty upper part (bits 13:9), almost-full low part, almost-full upper part, then back to the start.
  - Bits of the upper-part word above the offset width are discarded.
- R5: Loading follows the method chosen at master reset. In serial mode `wen` has no effect. In word mode `sen` has no effect. With `ld` low, neither `sen` nor `wen` changes an offset.
- R6: A read-clock edge with `ren` and `ld` both high puts the next part onto `rdata` in the R4 order, with bits above the offset width read as 0. The value is visible after that edge and works in both modes. `rdata` is 0 after master reset and otherwise holds its value.
- R7: A partial reset (`prst` high on an edge) leaves both offsets and the mode unchanged. It blocks loads and readback on that edge. It returns the word-write step, the readback step and the serial bit position to their first position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock; all loading happens on its rising edge |
| rclk | input | 1 | Read clock; readback happens on its rising edge |
| mrst | input | 1 | Master reset, synchronous, active high, sampled on both clocks |
| prst | input | 1 | Partial reset, synchronous, active high, sampled on both clocks |
| ld | input | 1 | Load select: picks defaults and mode at master reset; qualifies every load and readback |
| sen | input | 1 | Serial shift enable |
| sdi | input | 1 | Serial data bit |
| wen | input | 1 | Word write enable |
| wdata | input | 9 | Word write data |
| ren | input | 1 | Readback enable |
| ae_ofs | output | 14 | Almost-empty offset |
| af_ofs | output | 14 | Almost-full offset |
| rdata | output | 9 | Readback word |

## Verification
Every result passes through exactly one register. An offset written by a serial bit or a word shows at `ae_ofs`/`af_ofs` one write-clock edge later, and a readback word shows on `rdata` one read-clock edge later. The bench drives inputs just after a falling edge and samples outputs at the next falling edge, half a period after the edge that captures the result. Several value patterns are loaded and read back in both modes while a bench model tracks the step and bit positions. The checks also cover the wrap of both sequences, the discarded upper bits, ignored enables and partial resets in the middle of a sequence.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

    // Width of the part index inside a sequence pointer (up to 16 parts).
    localparam int PART_IW = 4;

    // Default offsets chosen by the load-select level at master reset.
    localparam int unsigned DEF_WORD_MODE   = 127;
    localparam int unsigned DEF_SERIAL_MODE = 1023;

    typedef enum logic {
        SEL_AE = 1'b0,
        SEL_AF = 1'b1
    } ofs_sel_e;

    typedef struct packed {
        ofs_sel_e             sel;
        logic [PART_IW-1:0]   part;
    } seq_ptr_t;

    function automatic int unsigned parts_for(input int unsigned ofs_w,
                                              input int unsigned word_w);
        return (ofs_w + word_w - 1) / word_w;
    endfunction

    function automatic int unsigned default_offset(input logic serial_mode);
        return serial_mode ? DEF_SERIAL_MODE : DEF_WORD_MODE;
    endfunction

endpackage

// File: rtl/ofs_seq_ptr.sv
module ofs_seq_ptr
    import ofs_pkg::*;
#(
    parameter int PARTS = 2
) (
    input  logic     clk,
    input  logic     clr,
    input  logic     step,
    output seq_ptr_t ptr
);

    localparam logic [PART_IW-1:0] LAST_PART = PART_IW'(PARTS - 1);

    always_ff @(posedge clk) begin
        if (clr) begin
            ptr.sel  <= SEL_AE;
            ptr.part <= '0;
        end else if (step) begin
            if (ptr.part == LAST_PART) begin
                ptr.part <= '0;
                ptr.sel  <= (ptr.sel == SEL_AE) ? SEL_AF : SEL_AE;
            end else begin
                ptr.part <= ptr.part + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ofs_shift_ctr.sv
module ofs_shift_ctr #(
    parameter int OFS_W = 14,
    localparam int CHAIN = 2 * OFS_W,
    localparam int CW    = $clog2(CHAIN)
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          step,
    output logic [CW-1:0] idx
);

    localparam logic [CW-1:0] LAST = CW'(CHAIN - 1);

    always_ff @(posedge clk) begin
        if (clr) begin
            idx <= '0;
        end else if (step) begin
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
        end
    end

endmodule

// File: rtl/ofs_bank.sv
module ofs_bank
    import ofs_pkg::*;
#(
    parameter int OFS_W  = 14,
    parameter int WORD_W = 9,
    localparam int CW    = $clog2(2 * OFS_W)
) (
    input  logic              clk,
    input  logic              mrst,
    input  logic              mode_serial_in,
    input  logic              ser_en,
    input  logic [CW-1:0]     ser_idx,
    input  logic              ser_bit,
    input  logic              par_en,
    input  seq_ptr_t          par_ptr,
    input  logic [WORD_W-1:0] par_word,
    output logic [OFS_W-1:0]  ae_q,
    output logic [OFS_W-1:0]  af_q
);

    logic [OFS_W-1:0] def_val;

    always_comb begin
        def_val = OFS_W'(default_offset(mode_serial_in));
    end

    always_ff @(posedge clk) begin
        if (mrst) begin
            ae_q <= def_val;
            af_q <= def_val;
        end else begin
            for (int b = 0; b < OFS_W; b++) begin
                if (ser_en && ser_idx == CW'(b)) begin
                    ae_q[b] <= ser_bit;
                end else if (par_en && par_ptr.sel == SEL_AE &&
                             par_ptr.part == PART_IW'(b / WORD_W)) begin
                    ae_q[b] <= par_word[b % WORD_W];
                end
                if (ser_en && ser_idx == CW'(b + OFS_W)) begin
                    af_q[b] <= ser_bit;
                end else if (par_en && par_ptr.sel == SEL_AF &&
                             par_ptr.part == PART_IW'(b / WORD_W)) begin
                    af_q[b] <= par_word[b % WORD_W];
                end
            end
        end
    end

endmodule

// File: rtl/ofs_loader_top.sv
module ofs_loader_top
    import ofs_pkg::*;
#(
    parameter int DEPTH  = 16384,
    parameter int WORD_W = 9,
    localparam int OFS_W = $clog2(DEPTH),
    localparam int PARTS = int'(parts_for(OFS_W, WORD_W)),
    localparam int EXT_W = PARTS * WORD_W,
    localparam int CW    = $clog2(2 * OFS_W)
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              mrst,
    input  logic              prst,
    input  logic              ld,
    input  logic              sen,
    input  logic              sdi,
    input  logic              wen,
    input  logic [WORD_W-1:0] wdata,
    input  logic              ren,
    output logic [OFS_W-1:0]  ae_ofs,
    output logic [OFS_W-1:0]  af_ofs,
    output logic [WORD_W-1:0] rdata
);

    logic          serial_q;
    logic          seq_clr;
    logic          ser_en;
    logic          par_en;
    logic          rd_en;
    logic [CW-1:0] ser_idx;
    seq_ptr_t      wr_ptr;
    seq_ptr_t      rd_ptr;

    // Mode is captured only by master reset; partial reset leaves it alone.
    always_ff @(posedge wclk) begin
        if (mrst) begin
            serial_q <= ld;
        end
    end

    always_comb begin
        seq_clr = mrst | prst;
        ser_en  = !seq_clr && ld && sen && serial_q;
        par_en  = !seq_clr && ld && wen && !serial_q;
        rd_en   = !seq_clr && ld && ren;
    end

    ofs_shift_ctr #(.OFS_W(OFS_W)) shift_ctr_i (
        .clk  (wclk),
        .clr  (seq_clr),
        .step (ser_en),
        .idx  (ser_idx)
    );

    ofs_seq_ptr #(.PARTS(PARTS)) wr_seq_i (
        .clk  (wclk),
        .clr  (seq_clr),
        .step (par_en),
        .ptr  (wr_ptr)
    );

    ofs_seq_ptr #(.PARTS(PARTS)) rd_seq_i (
        .clk  (rclk),
        .clr  (seq_clr),
        .step (rd_en),
        .ptr  (rd_ptr)
    );

    ofs_bank #(.OFS_W(OFS_W), .WORD_W(WORD_W)) bank_i (
        .clk            (wclk),
        .mrst           (mrst),
        .mode_serial_in (ld),
        .ser_en         (ser_en),
        .ser_idx        (ser_idx),
        .ser_bit        (sdi),
        .par_en         (par_en),
        .par_ptr        (wr_ptr),
        .par_word       (wdata),
        .ae_q           (ae_ofs),
        .af_q           (af_ofs)
    );

    // Readback: offsets are treated as quasi-static across the clock boundary.
    logic [EXT_W-1:0]  rd_src;
    logic [WORD_W-1:0] rd_word;

    always_comb begin
        rd_src  = (rd_ptr.sel == SEL_AE) ? EXT_W'(ae_ofs) : EXT_W'(af_ofs);
        rd_word = '0;
        for (int p = 0; p < PARTS; p++) begin
            if (rd_ptr.part == PART_IW'(p)) begin
                rd_word = rd_src[p*WORD_W +: WORD_W];
            end
        end
    end

    always_ff @(posedge rclk) begin
        if (mrst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_word;
        end
    end

endmodule

// File: rtl/ofs_loader_chk.sv
module ofs_loader_chk #(
    parameter int OFS_W  = 14,
    parameter int WORD_W = 9
) (
    input logic              wclk,
    input logic              rclk,
    input logic              mrst,
    input logic              prst,
    input logic              ld,
    input logic              sen,
    input logic              wen,
    input logic              ren,
    input logic              serial_q,
    input logic [OFS_W-1:0]  ae_ofs,
    input logic [OFS_W-1:0]  af_ofs,
    input logic [WORD_W-1:0] rdata
);

    // R1 R2
    default_after_mrst_chk: assert property (@(posedge wclk) disable iff (mrst)
        $past(mrst) |-> (ae_ofs == af_ofs) &&
                        (ae_ofs == ($past(ld) ? OFS_W'(1023) : OFS_W'(127))));

    // R3
    serial_one_bit_chk: assert property (@(posedge wclk) disable iff (mrst)
        (!$past(mrst) && serial_q) |->
            $countones({ae_ofs ^ $past(ae_ofs), af_ofs ^ $past(af_ofs)}) <= 1);

    // R5
    no_load_stable_chk: assert property (@(posedge wclk) disable iff (mrst)
        (!$past(mrst) && !($past(ld) && ($past(sen) || $past(wen)))) |->
            ($stable(ae_ofs) && $stable(af_ofs)));

    // R6
    rdata_hold_chk: assert property (@(posedge rclk) disable iff (mrst)
        (!$past(mrst) && !($past(ren) && $past(ld))) |-> $stable(rdata));

    // R7
    prst_keeps_chk: assert property (@(posedge wclk) disable iff (mrst)
        (!$past(mrst) && $past(prst)) |->
            ($stable(ae_ofs) && $stable(af_ofs) && $stable(serial_q)));

endmodule

bind ofs_loader_top ofs_loader_chk #(.OFS_W(OFS_W), .WORD_W(WORD_W)) chk_i (
    .wclk     (wclk),
    .rclk     (rclk),
    .mrst     (mrst),
    .prst     (prst),
    .ld       (ld),
    .sen      (sen),
    .wen      (wen),
    .ren      (ren),
    .serial_q (serial_q),
    .ae_ofs   (ae_ofs),
    .af_ofs   (af_ofs),
    .rdata    (rdata)
);

// File: tb/ofs_loader_top_tb_top.sv
`timescale 1ns/1ps
module ofs_loader_top_tb_top;

    localparam int W     = 14;
    localparam int WW    = 9;
    localparam int PARTS = 2;

    logic          clk = 1'b0;
    logic          mrst, prst, ld, sen, sdi, wen, ren;
    logic [WW-1:0] wdata;
    logic [W-1:0]  ae_ofs, af_ofs;
    logic [WW-1:0] rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Bench model
    int  m_ae, m_af, m_rd;
    int  m_k, m_ws, m_rs;
    bit  m_serial;

    always #5 clk = ~clk;

    ofs_loader_top dut_i (
        .wclk(clk), .rclk(clk), .mrst(mrst), .prst(prst), .ld(ld),
        .sen(sen), .sdi(sdi), .wen(wen), .wdata(wdata), .ren(ren),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs), .rdata(rdata)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_ofs(input string req);
        check(req, int'(ae_ofs), m_ae);
        check(req, int'(af_ofs), m_af);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        {mrst, prst, ld, sen, sdi, wen, ren} = '0;
        wdata = '0;
    endtask

    function automatic int ins_part(input int v, input int p, input int w);
        int mask;
        mask = (((1 << WW) - 1) << (p * WW)) & ((1 << W) - 1);
        return (v & ~mask) | ((w << (p * WW)) & mask);
    endfunction

    function automatic int get_part(input int v, input int p);
        return (v >> (p * WW)) & ((1 << WW) - 1);
    endfunction

    task automatic do_mrst(input bit sel);
        mrst = 1; ld = sel;
        step();
        m_serial = sel;
        m_ae = sel ? 1023 : 127;
        m_af = m_ae;
        m_rd = 0; m_k = 0; m_ws = 0; m_rs = 0;
    endtask

    task automatic do_prst();
        prst = 1; ld = 1; sen = 1; wen = 1; ren = 1; wdata = 9'h1A5; sdi = 1;
        step();
        m_k = 0; m_ws = 0; m_rs = 0;
    endtask

    task automatic do_par(input int w);
        wen = 1; ld = 1; wdata = WW'(w);
        step();
        if (!m_serial) begin
            if (m_ws / PARTS == 0) m_ae = ins_part(m_ae, m_ws % PARTS, w);
            else                   m_af = ins_part(m_af, m_ws % PARTS, w);
            m_ws = (m_ws + 1) % (2 * PARTS);
        end
    endtask

    task automatic do_ser(input bit b);
        sen = 1; ld = 1; sdi = b;
        step();
        if (m_serial) begin
            if (m_k < W) m_ae = (m_ae & ~(1 << m_k)) | (int'(b) << m_k);
            else         m_af = (m_af & ~(1 << (m_k - W))) | (int'(b) << (m_k - W));
            m_k = (m_k + 1) % (2 * W);
        end
    endtask

    task automatic do_read();
        ren = 1; ld = 1;
        step();
        m_rd = get_part((m_rs / PARTS == 0) ? m_ae : m_af, m_rs % PARTS);
        m_rs = (m_rs + 1) % (2 * PARTS);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1_500_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        {mrst, prst, ld, sen, sdi, wen, ren} = '0;
        wdata = '0;
        mrst = 1;
        @(negedge clk);

        // ---------------- word mode ----------------
        do_mrst(0);
        check_ofs("R1 default 127");
        check("R1 rdata after reset", int'(rdata), 0);

        // R4: sweep of value pairs loaded by words, each read back (R6)
        for (int i = 0; i < 12; i++) begin
            int a, f;
            a = (i == 0) ? 0 : (i == 1) ? (1 << W) - 1 : (i * 2731 + 5) % (1 << W);
            f = (i == 0) ? (1 << W) - 1 : (i == 1) ? 0 : (i * 977 + 3) % (1 << W);
            do_par(get_part(a, 0));
            check_ofs("R4 after AE low part");
            do_par(get_part(a, 1));
            do_par(get_part(f, 0));
            do_par(get_part(f, 1));
            check_ofs("R4 full load");
            check("R4 ae value", int'(ae_ofs), a);
            check("R4 af value", int'(af_ofs), f);
            for (int r = 0; r < 2 * PARTS; r++) begin
                do_read();
                check("R6 readback word mode", int'(rdata), m_rd);
            end
        end

        // R4: upper bits above offset width discarded
        do_par(9'h000);
        do_par(9'h1FF);
        check("R4 upper bits discarded", int'(ae_ofs), 14'h3E00);
        do_par(9'h0AA);
        do_par(9'h1E3);
        check_ofs("R4 af upper part");
        do_par(9'h155);
        check("R4 wrap to AE low", int'(ae_ofs), m_ae);
        check_ofs("R4 wrap");

        // R6: upper readback bits are zero; ren without ld holds rdata
        do_read();
        check("R6 readback wrap", int'(rdata), m_rd);
        do_read();
        check("R6 upper part zero-filled", int'(rdata), m_rd);
        ren = 1;
        step();
        check("R6 ren without ld holds", int'(rdata), m_rd);

        // R5: sen ignored in word mode; wen without ld ignored
        for (int i = 0; i < 6; i++) do_ser(i[0]);
        check_ofs("R5 sen ignored in word mode");
        wen = 1; wdata = 9'h0F0;
        step();
        check_ofs("R5 wen without ld ignored");

        // R7: partial reset mid-sequence
        do_prst();
        do_par(9'h011);
        do_prst();
        check_ofs("R7 offsets kept over prst");
        do_par(9'h123);
        check("R7 word step restarted at AE low", int'(ae_ofs), m_ae);
        check_ofs("R7 after restart");
        do_read();
        do_prst();
        do_read();
        check("R7 read step restarted", int'(rdata), m_rd);
        for (int i = 0; i < 4; i++) do_ser(1);
        check_ofs("R7 mode kept word after prst");

        // ---------------- serial mode ----------------
        do_mrst(1);
        check_ofs("R2 default 1023");
        check("R2 rdata after reset", int'(rdata), 0);

        // R5: wen ignored in serial mode; sen without ld ignored
        do_par(9'h155);
        do_par(9'h0AA);
        check_ofs("R5 wen ignored in serial mode");
        sen = 1; sdi = 1;
        step();
        check_ofs("R5 sen without ld ignored");

        // R3: bit-by-bit serial sweep over several patterns
        for (int i = 0; i < 6; i++) begin
            int a, f;
            a = (i * 5923 + 11) % (1 << W);
            f = (i * 1361 + 7) % (1 << W);
            for (int b = 0; b < 2 * W; b++) begin
                do_ser((b < W) ? a[b] : f[b - W]);
                check_ofs("R3 serial bit");
            end
            check("R3 ae value", int'(ae_ofs), a);
            check("R3 af value", int'(af_ofs), f);
            for (int r = 0; r < 2 * PARTS; r++) begin
                do_read();
                check("R6 readback serial mode", int'(rdata), m_rd);
            end
        end

        // R7: partial reset in the middle of a serial chain
        do_ser(0); do_ser(1); do_ser(0);
        do_prst();
        check_ofs("R7 offsets kept in serial mode");
        do_ser(1);
        check("R7 serial restarts at AE bit0", int'(ae_ofs), m_ae);
        do_par(9'h000);
        check_ofs("R7 mode kept serial after prst");

        finish_run();
    end

endmodule